// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block moves data between two parallel buses, side A and side B, along two independent paths: one from A to B and one from B to A. Each path holds one storage word and takes its mode from its own pins. With the latch-enable pin high the path is transparent and the far side follows the near side. With latch enable low the word is held, except that a low-to-high transition on the path's own strobe clock loads the current near-side data. A per-path output enable decides whether the far side is driven. The A-to-B enable is active high and the B-to-A enable is active low.

The block sits on a fast system clock. Every control pin and both data buses are sampled once per system cycle, and strobe-clock edges are found by comparing two successive samples. No tri-state logic is used inside the block. Each side has a data output and a drive flag, and a pad wrapper above the block turns these into bidirectional pins. A disabled side shows all zeros on its data output. The data width is a parameter and defaults to 18 bits.

Top module: `dualRegXcvr`

## Requirements
- R1: Every bit of a path obeys the same latch enable, strobe clock and output enable of that path, across the full `DATA_W` width (default 18).
- R2: While `abLatchEn` is high, `bOut` equals the `aIn` value that was present two system clock edges earlier.
- R3: While `abLatchEn` is low and `abClk` shows no low-to-high transition between two successive samples, the A-to-B stored word does not change, whatever `aIn` does. This holds with the strobe clock held low and with it held high.
- R4: While `abLatchEn` is low, a sampled low-to-high transition of `abClk` loads `aIn`. The new word appears on `bOut` two edges after the pins were driven. A high-to-low transition loads nothing.
- R5: `abOutEn` is active high. One edge after it is sampled low, `bOutValid` is 0 and `bOut` is all zeros, in every mode. The stored word keeps being updated while the output is disabled.
- R6: The B-to-A path behaves like the A-to-B path, with `bIn`, `baLatchEn` and `baClk` feeding `aOut`. Its enable `baOutEnN` is active low: 1 disables the output and 0 enables it.
- R7: When the latch enable falls while the strobe clock is low, the path keeps the word it was passing just before the fall. Data present on the same cycle as the fall is not stored.
- R8: An active-low synchronous `rstN` clears both stored words to zero and forces `aOutValid` and `bOutValid` to 0 until the enable pins are sampled after release.
- R9: The two paths are independent. Both sides may be driven at once, and no pin of one path changes the output of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all pins and advances all state |
| rstN | input | 1 | Synchronous reset, active low |
| aIn | input | DATA_W | Data arriving from side A |
| bIn | input | DATA_W | Data arriving from side B |
| abLatchEn | input | 1 | A-to-B transparency control, high = transparent |
| abClk | input | 1 | A-to-B strobe clock, loads on rising transition |
| abOutEn | input | 1 | Side B drive enable, active high |
| baLatchEn | input | 1 | B-to-A transparency control, high = transparent |
| baClk | input | 1 | B-to-A strobe clock, loads on rising transition |
| baOutEnN | input | 1 | Side A drive enable, active low |
| aOut | output | DATA_W | Word for side A, zero when not driven |
| aOutValid | output | 1 | Side A pads should drive |
| bOut | output | DATA_W | Word for side B, zero when not driven |
| bOutValid | output | 1 | Side B pads should drive |

## Verification
A corrupted stored word shows up on the enabled output one system edge after the faulty update, which is two edges after the pins that caused it. A held word that drifts is therefore caught within a cycle of the drift. A wrong strobe-clock history shows up as a missing or extra load. It is exposed by driving new data on the same cycle as a rising or falling strobe transition and then reading the output over the following idle cycles. A wrong drive flag is visible one edge after the enable pin changes, and the zero-gating makes it visible on the data output as well.

// File: rtl/xcvrPkg.sv
package xcvrPkg;
  // Per-direction strobes from control to datapath
  typedef struct packed {
    logic load;   // write the sampled input into storage this edge
    logic drive;  // far side is being driven
  } dirStrobe_t;
endpackage

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import xcvrPkg::*;
#(
  parameter bit EN_ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchEn,
  input  logic       busClk,
  input  logic       outEnPin,
  output dirStrobe_t strobe
);
  logic enNorm;
  logic leSmp, clkSmp, clkPrev, enSmp;

  // Polarity of the enable pin is fixed per instance
  generate
    if (EN_ACTIVE_LOW) begin : g_enLow
      assign enNorm = ~outEnPin;
    end else begin : g_enHigh
      assign enNorm = outEnPin;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leSmp   <= 1'b0;
      clkSmp  <= 1'b0;
      clkPrev <= 1'b0;
      enSmp   <= 1'b0;
    end else begin
      leSmp   <= latchEn;
      clkSmp  <= busClk;
      clkPrev <= clkSmp;
      enSmp   <= enNorm;
    end
  end

  // Transparent mode loads every cycle; otherwise only on a rising strobe
  assign strobe.load  = leSmp | (clkSmp & ~clkPrev);
  assign strobe.drive = enSmp;
endmodule

// File: rtl/xcvrPath.sv
module xcvrPath
  import xcvrPkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  dirStrobe_t        strobe,
  output logic [DATA_W-1:0] dOut,
  output logic              drive
);
  logic [DATA_W-1:0] dataSmp;
  logic [DATA_W-1:0] store;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataSmp <= '0;
      store   <= '0;
    end else begin
      dataSmp <= dIn;
      if (strobe.load) store <= dataSmp;
    end
  end

  assign dOut  = strobe.drive ? store : '0;
  assign drive = strobe.drive;
endmodule

// File: rtl/dualRegXcvr.sv
module dualRegXcvr
  import xcvrPkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              abLatchEn,
  input  logic              abClk,
  input  logic              abOutEn,
  input  logic              baLatchEn,
  input  logic              baClk,
  input  logic              baOutEnN,
  output logic [DATA_W-1:0] aOut,
  output logic              aOutValid,
  output logic [DATA_W-1:0] bOut,
  output logic              bOutValid
);
  dirStrobe_t abStrobe, baStrobe;

  xcvrCtrl #(.EN_ACTIVE_LOW(1'b0)) u_abCtrl (
    .clk(clk), .rstN(rstN), .latchEn(abLatchEn), .busClk(abClk),
    .outEnPin(abOutEn), .strobe(abStrobe)
  );

  xcvrCtrl #(.EN_ACTIVE_LOW(1'b1)) u_baCtrl (
    .clk(clk), .rstN(rstN), .latchEn(baLatchEn), .busClk(baClk),
    .outEnPin(baOutEnN), .strobe(baStrobe)
  );

  xcvrPath #(.DATA_W(DATA_W)) u_abPath (
    .clk(clk), .rstN(rstN), .dIn(aIn), .strobe(abStrobe),
    .dOut(bOut), .drive(bOutValid)
  );

  xcvrPath #(.DATA_W(DATA_W)) u_baPath (
    .clk(clk), .rstN(rstN), .dIn(bIn), .strobe(baStrobe),
    .dOut(aOut), .drive(aOutValid)
  );
endmodule

// File: rtl/dualRegXcvrChk.sv
module dualRegXcvrChk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] bIn,
  input logic              abLatchEn,
  input logic              abClk,
  input logic              abOutEn,
  input logic              baLatchEn,
  input logic              baClk,
  input logic              baOutEnN,
  input logic [DATA_W-1:0] aOut,
  input logic              aOutValid,
  input logic [DATA_W-1:0] bOut,
  input logic              bOutValid
);
  // Edges since reset release, saturating; gates history-based checks
  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (!rstN) cyc <= 3'd0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  a_r8_reset_disables: assert property (@(posedge clk)
    !rstN |=> (!aOutValid && !bOutValid && aOut == '0 && bOut == '0));

  a_r2_ab_follow: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd2 && $past(abLatchEn, 2) && bOutValid) |-> bOut == $past(aIn, 2));

  a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd4 && !$past(abLatchEn, 2) && !($past(abClk, 2) && !$past(abClk, 3))
     && bOutValid && $past(bOutValid)) |-> $stable(bOut));

  a_r4_ab_capture: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd4 && !$past(abLatchEn, 2) && $past(abClk, 2) && !$past(abClk, 3)
     && bOutValid) |-> bOut == $past(aIn, 2));

  a_r5_ab_disable: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd1 && !$past(abOutEn)) |-> (!bOutValid && bOut == '0));

  a_r7_ab_le_fall: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd4 && $past(abLatchEn, 3) && !$past(abLatchEn, 2) && !$past(abClk, 2)
     && bOutValid) |-> bOut == $past(aIn, 3));

  a_r6_ba_follow: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd2 && $past(baLatchEn, 2) && aOutValid) |-> aOut == $past(bIn, 2));

  a_r6_ba_capture: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd4 && !$past(baLatchEn, 2) && $past(baClk, 2) && !$past(baClk, 3)
     && aOutValid) |-> aOut == $past(bIn, 2));

  a_r6_ba_disable: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd1 && $past(baOutEnN)) |-> (!aOutValid && aOut == '0));

  a_r6_ba_enable: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd1 && !$past(baOutEnN)) |-> aOutValid);
endmodule

bind dualRegXcvr dualRegXcvrChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
  .abLatchEn(abLatchEn), .abClk(abClk), .abOutEn(abOutEn),
  .baLatchEn(baLatchEn), .baClk(baClk), .baOutEnN(baOutEnN),
  .aOut(aOut), .aOutValid(aOutValid), .bOut(bOut), .bOutValid(bOutValid)
);

// File: tb/dualRegXcvr_tb.sv
`timescale 1ns/1ps
module dualRegXcvr_tb;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rstN;
  logic [W-1:0] aIn, bIn, aOut, bOut;
  logic abLatchEn, abClk, abOutEn, baLatchEn, baClk, baOutEnN;
  logic aOutValid, bOutValid;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dualRegXcvr #(.DATA_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .abLatchEn(abLatchEn), .abClk(abClk), .abOutEn(abOutEn),
    .baLatchEn(baLatchEn), .baClk(baClk), .baOutEnN(baOutEnN),
    .aOut(aOut), .aOutValid(aOutValid), .bOut(bOut), .bOutValid(bOutValid)
  );

  function automatic logic [W-1:0] pat(input int i);
    logic [31:0] t;
    if (i < W) return W'(1) << i;
    t = i * 32'h0002_F1B3 + 32'h0000_0155;
    return t[W-1:0];
  endfunction

  // dir 0: A->B (enable active high), dir 1: B->A (enable pin active low)
  task automatic setCtl(input int dir, input logic le, input logic ck, input logic en);
    if (dir == 0) begin abLatchEn = le; abClk = ck; abOutEn = en; end
    else begin baLatchEn = le; baClk = ck; baOutEnN = ~en; end
  endtask

  task automatic setIn(input int dir, input logic [W-1:0] v);
    if (dir == 0) aIn = v; else bIn = v;
  endtask

  function automatic logic [W-1:0] farOut(input int dir);
    return (dir == 0) ? bOut : aOut;
  endfunction

  function automatic logic farVld(input int dir);
    return (dir == 0) ? bOutValid : aOutValid;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int dir, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dir%0d: got %h expected %h", tag, dir, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held, v;
    string tg;
    // R8: enables asserted and data present during reset must not leak
    rstN = 1'b0;
    aIn = '1; bIn = '1;
    abLatchEn = 1'b0; abClk = 1'b0; abOutEn = 1'b1;
    baLatchEn = 1'b0; baClk = 1'b0; baOutEnN = 1'b0;
    step(4);
    chk("R8 valid during reset", 0, W'(bOutValid), '0);
    chk("R8 valid during reset", 1, W'(aOutValid), '0);
    chk("R8 data during reset", 0, bOut, '0);
    chk("R8 data during reset", 1, aOut, '0);
    rstN = 1'b1;
    step(1);
    chk("R8 enable after release", 0, W'(bOutValid), W'(1));
    chk("R8 enable after release", 1, W'(aOutValid), W'(1));
    step(2);
    chk("R8 storage cleared", 0, bOut, '0);
    chk("R8 storage cleared", 1, aOut, '0);

    for (int dir = 0; dir < 2; dir++) begin
      tg = (dir == 0) ? "" : "R6/";
      // R2 / R1: transparent sweep, one new word per cycle, two-edge lag
      setCtl(dir, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 48; i++) begin
        if (i >= 2) chk({tg, "R2/R1 transparent"}, dir, farOut(dir), pat(i - 2));
        setIn(dir, pat(i));
        step(1);
      end
      // R7: latch enable falls with strobe clock low; same-cycle data is dropped
      held = pat(90);
      setIn(dir, held);
      step(3);
      setCtl(dir, 1'b0, 1'b0, 1'b1);
      setIn(dir, ~held);
      step(3);
      chk({tg, "R7 keep pre-fall word"}, dir, farOut(dir), held);
      // R3: clock held low, data churning
      for (int i = 0; i < 6; i++) begin
        setIn(dir, pat(i + 200));
        step(1);
        chk({tg, "R3 hold clk low"}, dir, farOut(dir), held);
      end
      // R4 / R3: rising loads, high hold keeps, falling loads nothing
      for (int k = 0; k < 6; k++) begin
        v = pat(k + 60);
        setIn(dir, v);
        setCtl(dir, 1'b0, 1'b1, 1'b1);
        step(2);
        chk({tg, "R4 rising capture"}, dir, farOut(dir), v);
        setIn(dir, ~v);
        step(3);
        chk({tg, "R3 hold clk high"}, dir, farOut(dir), v);
        setCtl(dir, 1'b0, 1'b0, 1'b1);
        setIn(dir, v ^ pat(k + 300));
        step(3);
        chk({tg, "R4 falling no capture"}, dir, farOut(dir), v);
      end
      // R5: disabled output is flagged off and zero; storage keeps tracking
      setCtl(dir, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) begin
        setIn(dir, pat(i + 400) | W'(1));
        step(1);
        chk({tg, "R5 disabled flag"}, dir, W'(farVld(dir)), '0);
        chk({tg, "R5 disabled data"}, dir, farOut(dir), '0);
      end
      v = pat(500);
      setIn(dir, v);
      step(2);
      setCtl(dir, 1'b1, 1'b0, 1'b1);
      step(1);
      chk({tg, "R5 re-enabled flag"}, dir, W'(farVld(dir)), W'(1));
      chk({tg, "R5 storage tracked while off"}, dir, farOut(dir), v);
    end

    // R9: B->A holds while A->B runs transparent and its strobe toggles
    held = pat(777);
    setCtl(1, 1'b1, 1'b0, 1'b1);
    setIn(1, held);
    step(3);
    setCtl(1, 1'b0, 1'b0, 1'b1);
    step(2);
    for (int i = 0; i < 10; i++) begin
      v = pat(i + 600);
      setIn(0, v);
      setIn(1, ~v);
      setCtl(0, 1'b1, i[0], 1'b1);
      step(2);
      chk("R9 A->B runs", 0, bOut, v);
      chk("R9 B->A undisturbed", 1, aOut, held);
      chk("R9 both driven", 1, W'(aOutValid & bOutValid), W'(1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule